// File: doc/BRIEF.md
# Dual-Format Stereo Baseband Serial Port

This block moves stereo PCM samples of up to 18 bits over a three-wire serial link: a bit clock, a word select and one data line. The block is the link master. It makes the bit clock from a system-clock enable and places 64 bit slots in every word-select period, 32 for each channel. One direction input picks transmit or receive. In transmit mode a parallel left/right pair, taken through a valid/ready handshake, is shifted out MSB first. In receive mode the serial data is shifted in and handed out as a parallel pair with a valid/ready handshake.

Two slot alignments can be picked at run time. In standard I2S alignment the MSB follows the word-select edge after one bit clock. In no-delay alignment the MSB sits in the very first slot of the half frame. A frame sequencer with four states steps through each half frame. SQ_IDLE holds until the first frame begins. SQ_LEAD is the delay slot of standard alignment. SQ_DATA covers the sample bits, counted down from MSB to LSB. SQ_PAD covers the unused remainder of the half. On every bit-clock falling edge that opens a half frame, the sequencer enters SQ_LEAD (standard) or SQ_DATA (no-delay). SQ_LEAD then goes to SQ_DATA. SQ_DATA goes to SQ_PAD after the LSB. SQ_PAD waits for the next half.

Top module: `bbsp_top`

## Requirements
- R1: Every cycle with `bclk_en` high toggles `sclk_o`, starting low after reset. `ws_o` is low (left channel) for 32 bit-clock periods and then high (right channel) for 32, which gives 64 bit clocks per sample period.
- R2: `ws_o` and `sd_o` change only in a cycle in which `sclk_o` falls.
- R3: With `fmt_sel` = 0 (standard I2S alignment), slot 0 of each half is 0. The 18 sample bits occupy slots 1..18 and slots 19..31 carry 0.
- R4: With `fmt_sel` = 1 (no-delay alignment), the 18 sample bits occupy slots 0..17 and slots 18..31 carry 0.
- R5: Samples are sent MSB first. The left sample goes in the half with `ws_o` low and the right sample in the half with `ws_o` high.
- R6: `fmt_sel` and `dir_sel` are sampled only at the falling edge of `ws_o`. A change made during a frame leaves both halves of that frame unaffected.
- R7: `tx_ready` is high while the one-pair holding register is empty. A pair is taken when `tx_valid` and `tx_ready` are both high. That pair is sent in the frame that begins at the next `ws_o` falling edge.
- R8: When no pair is held at the start of a frame, the whole frame carries 0.
- R9: In receive mode (`dir_sel` = 1), `sd_i` is sampled on the `sclk_o` rising edge in the same slots that R3/R4 give. Bits in unused slots are discarded. After the right LSB, `rx_valid` rises with the pair. It stays high until `rx_ready` is high, and a newer pair overwrites an unread one.
- R10: In receive mode `sd_o` stays 0.
- R11: During reset `sclk_o` = 0, `ws_o` = 1, `sd_o` = 0, `tx_ready` = 1 and `rx_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_en | input | 1 | Bit-clock enable, one bit-clock half period per pulse |
| fmt_sel | input | 1 | 0 = standard I2S alignment, 1 = no-delay alignment |
| dir_sel | input | 1 | 0 = transmit, 1 = receive |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Holding register free |
| tx_left | input | DW | Left transmit sample |
| tx_right | input | DW | Right transmit sample |
| rx_valid | output | 1 | Received pair available |
| rx_ready | input | 1 | Received pair consumed |
| rx_left | output | DW | Left received sample |
| rx_right | output | DW | Right received sample |
| sclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select, low = left |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
The assertions check on every cycle that word select and data move only with a falling bit clock. They also check that the sequencer's delay slot and first data slot line up with the slot counter for each alignment, that the latched format moves only at a frame start, that an accepted pair fills the holding register and that an unread received pair is held. The bench scenarios are the only place that shows the serial content itself. They confirm the decoded samples and zero padding in both alignments, silence on underrun, a mid-frame change of format or direction, the receive path discarding garbage padding, and the data line staying quiet during reception.

// File: rtl/bbsp_pkg.sv
package bbsp_pkg;

    typedef enum logic {
        FMT_STD = 1'b0,
        FMT_ALT = 1'b1
    } fmt_e;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LEAD = 2'd1,
        SQ_DATA = 2'd2,
        SQ_PAD  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/bbsp_clkgen.sv
module bbsp_clkgen #(
    parameter int SLOTS = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bclk_en,
    output logic                      sclk,
    output logic                      ws,
    output logic                      fall_tick,
    output logic                      rise_tick,
    output logic                      frame_start,
    output logic                      half_start,
    output logic [$clog2(SLOTS)-1:0]  slot
);
    localparam int SW = $clog2(SLOTS);

    logic          sclk_q;
    logic          ws_q;
    logic [SW-1:0] slot_q;
    logic [SW-1:0] slot_nx;

    assign fall_tick   = bclk_en & sclk_q;
    assign rise_tick   = bclk_en & ~sclk_q;
    assign slot_nx     = slot_q + SW'(1);
    assign frame_start = fall_tick && (slot_nx == '0);
    assign half_start  = fall_tick && (slot_nx[SW-2:0] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            ws_q   <= 1'b1;
            slot_q <= '1;
        end else begin
            if (bclk_en) begin
                sclk_q <= ~sclk_q;
            end
            if (fall_tick) begin
                slot_q <= slot_nx;
                ws_q   <= slot_nx[SW-1];
            end
        end
    end

    assign sclk = sclk_q;
    assign ws   = ws_q;
    assign slot = slot_q;

    // R2: word select moves only together with a falling bit clock
    a_r2_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws_q) |-> $fell(sclk_q));

endmodule

// File: rtl/bbsp_seq.sv
module bbsp_seq
    import bbsp_pkg::*;
#(
    parameter int DW    = 18,
    parameter int SLOTS = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fall_tick,
    input  logic                      frame_start,
    input  logic                      half_start,
    input  logic [$clog2(SLOTS)-1:0]  slot,
    input  fmt_e                      fmt_in,
    input  dir_e                      dir_in,
    output logic                      data_slot,
    output logic [$clog2(DW)-1:0]     bit_idx,
    output fmt_e                      fmt_q,
    output dir_e                      dir_q
);
    localparam int SW = $clog2(SLOTS);
    localparam int BW = $clog2(DW);
    localparam logic [BW-1:0] MSB_IDX = BW'(DW - 1);

    seq_state_e    state_q, state_nx;
    logic [BW-1:0] bcnt_q, bcnt_nx;
    fmt_e          fmt_eff;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            bcnt_q  <= MSB_IDX;
            fmt_q   <= FMT_STD;
            dir_q   <= DIR_TX;
        end else begin
            state_q <= state_nx;
            bcnt_q  <= bcnt_nx;
            if (frame_start) begin
                fmt_q <= fmt_in;
                dir_q <= dir_in;
            end
        end
    end

    // next state: a new half restarts the walk, otherwise step per slot
    always_comb begin
        state_nx = state_q;
        bcnt_nx  = bcnt_q;
        fmt_eff  = frame_start ? fmt_in : fmt_q;
        if (half_start) begin
            bcnt_nx  = MSB_IDX;
            state_nx = (fmt_eff == FMT_STD) ? SQ_LEAD : SQ_DATA;
        end else if (fall_tick) begin
            unique case (state_q)
                SQ_IDLE: begin
                    state_nx = SQ_IDLE;
                end
                SQ_LEAD: begin
                    state_nx = SQ_DATA;
                end
                SQ_DATA: begin
                    if (bcnt_q == '0) begin
                        state_nx = SQ_PAD;
                    end else begin
                        bcnt_nx = bcnt_q - BW'(1);
                    end
                end
                SQ_PAD: begin
                    state_nx = SQ_PAD;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        data_slot = (state_q == SQ_DATA);
        bit_idx   = bcnt_q;
    end

    // R3: the delay slot is always the first slot of a half
    a_r3_lead_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_LEAD) |-> (slot[SW-2:0] == '0));

    // R3: standard alignment puts the MSB in slot 1
    a_r3_std_msb_slot1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_DATA && bcnt_q == MSB_IDX && fmt_q == FMT_STD)
        |-> (slot[SW-2:0] == (SW-1)'(1)));

    // R4: no-delay alignment puts the MSB in slot 0
    a_r4_alt_msb_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_DATA && bcnt_q == MSB_IDX && fmt_q == FMT_ALT)
        |-> (slot[SW-2:0] == '0));

    // R6: latched format moves only as a new left half begins
    a_r6_fmt_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fmt_q) |-> (slot == '0));

endmodule

// File: rtl/bbsp_tx.sv
module bbsp_tx
    import bbsp_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start,
    input  logic                   tx_valid,
    output logic                   tx_ready,
    input  logic [DW-1:0]          tx_left,
    input  logic [DW-1:0]          tx_right,
    input  logic                   data_slot,
    input  logic [$clog2(DW)-1:0]  bit_idx,
    input  logic                   right_half,
    input  dir_e                   dir_q,
    output logic                   sd_o
);
    logic [DW-1:0] hold_l, hold_r;
    logic [DW-1:0] cur_l, cur_r;
    logic          hold_full;
    logic          accept;
    logic          cur_bit;

    assign tx_ready = ~hold_full;
    assign accept   = tx_valid & ~hold_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_l    <= '0;
            hold_r    <= '0;
            cur_l     <= '0;
            cur_r     <= '0;
            hold_full <= 1'b0;
        end else begin
            if (frame_start) begin
                cur_l <= hold_full ? hold_l : '0;
                cur_r <= hold_full ? hold_r : '0;
            end
            if (accept) begin
                hold_l    <= tx_left;
                hold_r    <= tx_right;
                hold_full <= 1'b1;
            end else if (frame_start) begin
                hold_full <= 1'b0;
            end
        end
    end

    assign cur_bit = right_half ? cur_r[bit_idx] : cur_l[bit_idx];
    assign sd_o    = (dir_q == DIR_TX) && data_slot && cur_bit;

    // R7: an accepted pair occupies the holding register
    a_r7_full_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

endmodule

// File: rtl/bbsp_rx.sv
module bbsp_rx
    import bbsp_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rise_tick,
    input  logic                   data_slot,
    input  logic [$clog2(DW)-1:0]  bit_idx,
    input  logic                   right_half,
    input  dir_e                   dir_q,
    input  logic                   sd_i,
    output logic                   rx_valid,
    input  logic                   rx_ready,
    output logic [DW-1:0]          rx_left,
    output logic [DW-1:0]          rx_right
);
    logic [DW-1:0] sh_q, sh_nx, left_q;
    logic          take, last_bit, pair_done;

    assign sh_nx     = {sh_q[DW-2:0], sd_i};
    assign take      = rise_tick && (dir_q == DIR_RX) && data_slot;
    assign last_bit  = take && (bit_idx == '0);
    assign pair_done = last_bit && right_half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            left_q   <= '0;
            rx_left  <= '0;
            rx_right <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (take) begin
                sh_q <= sh_nx;
            end
            if (last_bit && !right_half) begin
                left_q <= sh_nx;
            end
            if (pair_done) begin
                rx_left  <= left_q;
                rx_right <= sh_nx;
                rx_valid <= 1'b1;
            end else if (rx_ready) begin
                rx_valid <= 1'b0;
            end
        end
    end

    // R9: an unread pair stays offered
    a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> rx_valid);

endmodule

// File: rtl/bbsp_top.sv
module bbsp_top
    import bbsp_pkg::*;
#(
    parameter int DW    = 18,
    parameter int SLOTS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_en,
    input  logic          fmt_sel,
    input  logic          dir_sel,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic [DW-1:0] tx_left,
    input  logic [DW-1:0] tx_right,
    output logic          rx_valid,
    input  logic          rx_ready,
    output logic [DW-1:0] rx_left,
    output logic [DW-1:0] rx_right,
    output logic          sclk_o,
    output logic          ws_o,
    output logic          sd_o,
    input  logic          sd_i
);
    localparam int SW = $clog2(SLOTS);
    localparam int BW = $clog2(DW);

    logic          fall_tick, rise_tick, frame_start, half_start;
    logic [SW-1:0] slot;
    logic          data_slot;
    logic [BW-1:0] bit_idx;
    fmt_e          fmt_q;
    dir_e          dir_q;

    bbsp_clkgen #(.SLOTS(SLOTS)) u_clk (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_en     (bclk_en),
        .sclk        (sclk_o),
        .ws          (ws_o),
        .fall_tick   (fall_tick),
        .rise_tick   (rise_tick),
        .frame_start (frame_start),
        .half_start  (half_start),
        .slot        (slot)
    );

    bbsp_seq #(.DW(DW), .SLOTS(SLOTS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_tick   (fall_tick),
        .frame_start (frame_start),
        .half_start  (half_start),
        .slot        (slot),
        .fmt_in      (fmt_e'(fmt_sel)),
        .dir_in      (dir_e'(dir_sel)),
        .data_slot   (data_slot),
        .bit_idx     (bit_idx),
        .fmt_q       (fmt_q),
        .dir_q       (dir_q)
    );

    bbsp_tx #(.DW(DW)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_left     (tx_left),
        .tx_right    (tx_right),
        .data_slot   (data_slot),
        .bit_idx     (bit_idx),
        .right_half  (ws_o),
        .dir_q       (dir_q),
        .sd_o        (sd_o)
    );

    bbsp_rx #(.DW(DW)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_tick   (rise_tick),
        .data_slot   (data_slot),
        .bit_idx     (bit_idx),
        .right_half  (ws_o),
        .dir_q       (dir_q),
        .sd_i        (sd_i),
        .rx_valid    (rx_valid),
        .rx_ready    (rx_ready),
        .rx_left     (rx_left),
        .rx_right    (rx_right)
    );

    // R2: serial data moves only together with a falling bit clock
    a_r2_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_o) |-> $fell(sclk_o));

endmodule

// File: tb/tb_bbsp_top.sv
module tb_bbsp_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_en = 1'b0;
    logic        fmt_sel = 1'b0;
    logic        dir_sel = 1'b0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [17:0] tx_left = '0;
    logic [17:0] tx_right = '0;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic [17:0] rx_left, rx_right;
    logic        sclk_o, ws_o, sd_o;
    logic        sd_i = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    int ce_div = 1;
    int ce_cnt = 0;

    logic [35:0] txq[$];
    logic [35:0] rxdq[$];
    logic [35:0] rxq[$];

    bbsp_top dut (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .fmt_sel(fmt_sel),
        .dir_sel(dir_sel), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_left(tx_left), .tx_right(tx_right), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_left(rx_left), .rx_right(rx_right),
        .sclk_o(sclk_o), .ws_o(ws_o), .sd_o(sd_o), .sd_i(sd_i)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // bit-clock enable pattern
    always @(negedge clk) begin
        if (!rst_n) begin
            bclk_en = 1'b0;
            ce_cnt  = 0;
        end else begin
            ce_cnt  = (ce_cnt + 1 >= ce_div) ? 0 : ce_cnt + 1;
            bclk_en = (ce_cnt == 0);
        end
    end

    // monitor and serial-side model
    logic        sclk_p = 1'b0, ws_pr = 1'b1, ws_pf = 1'b1;
    int          rise_pos = 0, f_pos = 0;
    bit          m_active = 0, m_fmt = 0, m_dir = 0, m_pad_err = 0, m_quiet_err = 0;
    int          m_rises = 0, m_high = 0;
    logic [17:0] m_l = '0, m_r = '0, e_l = '0, e_r = '0;
    bit          f_fmt = 0, f_dir = 0;
    logic [17:0] f_l = '0, f_r = '0;

    task automatic finalize_frame();
        chk(m_rises == 64, "R1", "bit clocks per frame", 64'(m_rises), 64);
        chk(m_high == 32, "R1", "right-half bit clocks", 64'(m_high), 32);
        if (!m_dir) begin
            // R5 order and R8 silence are both folded into this comparison
            chk({m_l, m_r} == {e_l, e_r}, m_fmt ? "R4" : "R3", "decoded pair",
                64'({m_l, m_r}), 64'({e_l, e_r}));
            chk(!m_pad_err, m_fmt ? "R4" : "R3", "unused slots zero",
                64'(m_pad_err), 0);
        end else begin
            chk(!m_quiet_err, "R10", "sd_o quiet in receive", 64'(m_quiet_err), 0);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_o && !sclk_p) begin
                if (ws_o != ws_pr) rise_pos = 0; else rise_pos++;
                if (!ws_o && ws_pr) begin
                    if (m_active) finalize_frame();
                    m_active = 1; m_fmt = fmt_sel; m_dir = dir_sel;
                    m_rises = 0; m_high = 0; m_l = '0; m_r = '0;
                    m_pad_err = 0; m_quiet_err = 0;
                    if (!m_dir) begin
                        if (txq.size() > 0) {e_l, e_r} = txq.pop_front();
                        else {e_l, e_r} = '0; // R8 underrun frame expected silent
                    end
                end
                ws_pr = ws_o;
                if (m_active) begin
                    bit in_data;
                    m_rises++;
                    if (ws_o) m_high++;
                    in_data = m_fmt ? (rise_pos <= 17) : (rise_pos >= 1 && rise_pos <= 18);
                    if (!m_dir) begin
                        // R5: MSB first, left sample while ws low
                        if (in_data) begin
                            if (ws_o) m_r = {m_r[16:0], sd_o};
                            else      m_l = {m_l[16:0], sd_o};
                        end else if (sd_o) m_pad_err = 1;
                    end else if (sd_o) m_quiet_err = 1;
                end
            end
            if (!sclk_o && sclk_p) begin
                bit in_d;
                logic [17:0] val;
                int idx;
                if (ws_o != ws_pf) f_pos = 0; else f_pos++;
                if (!ws_o && ws_pf) begin
                    f_fmt = fmt_sel; f_dir = dir_sel;
                    if (f_dir) begin
                        if (rxdq.size() > 0) {f_l, f_r} = rxdq.pop_front();
                        else {f_l, f_r} = '0;
                        rxq.push_back({f_l, f_r});
                    end
                end
                ws_pf = ws_o;
                in_d = f_fmt ? (f_pos <= 17) : (f_pos >= 1 && f_pos <= 18);
                val  = ws_o ? f_r : f_l;
                idx  = f_fmt ? 17 - f_pos : 18 - f_pos;
                // R9: unused slots carry garbage ones that must be discarded
                sd_i = in_d ? val[idx] : 1'b1;
            end
            if (rx_valid) begin
                if (rxq.size() > 0) begin
                    logic [35:0] e;
                    e = rxq.pop_front();
                    chk({rx_left, rx_right} == e, "R9", "received pair",
                        64'({rx_left, rx_right}), 64'(e));
                end else begin
                    chk(0, "R9", "unexpected rx_valid", 1, 0);
                end
            end
        end
        sclk_p = sclk_o;
    end

    task automatic wait_right();
        while (ws_o !== 1'b0) @(negedge clk);
        while (ws_o !== 1'b1) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_left();
        while (ws_o !== 1'b1) @(negedge clk);
        while (ws_o !== 1'b0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic tx_send(input logic [17:0] l, input logic [17:0] r);
        txq.push_back({l, r});
        tx_left = l; tx_right = r; tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R7", "holding register full after accept",
            64'(tx_ready), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(sclk_o == 1'b0, "R11", "sclk in reset", 64'(sclk_o), 0);
        chk(ws_o == 1'b1, "R11", "ws in reset", 64'(ws_o), 1);
        chk(sd_o == 1'b0, "R11", "sd in reset", 64'(sd_o), 0);
        chk(tx_ready == 1'b1, "R11", "tx_ready in reset", 64'(tx_ready), 1);
        chk(rx_valid == 1'b0, "R11", "rx_valid in reset", 64'(rx_valid), 0);
        rst_n = 1'b1;

        // transmit, standard alignment (R3, R7)
        wait_right(); tx_send(18'h2A5C3, 18'h15A3C);
        wait_right(); tx_send(18'h20001, 18'h1FFFF);
        wait_right(); tx_send(18'h3FFFF, 18'h00001);
        wait_right(); // no pair: underrun frame (R8)
        // transmit, no-delay alignment (R4)
        wait_right(); fmt_sel = 1'b1; tx_send(18'h12345, 18'h2DCBA);
        wait_right(); tx_send(18'h00000, 18'h3FFFF);
        wait_right(); tx_send(18'h20000, 18'h1F0F0);
        // R6: format change mid-left leaves this frame in no-delay alignment
        wait_right(); tx_send(18'h0F0F0, 18'h30303);
        wait_left(); repeat (6) @(negedge clk); fmt_sel = 1'b0;
        wait_right(); tx_send(18'h2AAAA, 18'h15555);
        // R6: direction change mid-left leaves this frame transmitting
        rxdq.push_back({18'h2B3C4, 18'h1D2E3});
        rxdq.push_back({18'h3FFFF, 18'h00000});
        rxdq.push_back({18'h20000, 18'h1FFFF});
        wait_left(); repeat (6) @(negedge clk); dir_sel = 1'b1;
        wait_right(); ce_div = 3;
        // receive, standard alignment (R9, R10)
        wait_right(); wait_right(); wait_right();
        // receive, no-delay alignment
        rxdq.push_back({18'h13579, 18'h2468A});
        rxdq.push_back({18'h00001, 18'h20001});
        fmt_sel = 1'b1;
        wait_right(); wait_right(); wait_right(); wait_right();
        chk(txq.size() == 0, "R7", "all pairs sent", 64'(txq.size()), 0);
        chk(rxq.size() <= 1, "R9", "all received pairs delivered", 64'(rxq.size()), 1);
        finish_run();
    end

endmodule